// File: doc/BRIEF.md
# 16-bit Gate-Level ALU

The block is a purely combinational arithmetic and logic unit for 16-bit data. It takes two operands and a 4-bit function code. It returns a 16-bit result and a flag that marks an all-zero result.

It offers two groups of functions:
- Bitwise: and, or, nor and nand.
- Arithmetic: add, subtract and signed set-less-than.

All three arithmetic functions share one ripple-carry adder. For subtract and set-less-than, the adder inverts the second operand and forces its carry-in to one.

The whole datapath is built from gate primitives. That covers the decode, the adder, the result selector and the zero detector. The block has no clock and no state, so it can sit inside any execute stage.

Top module: `alu16_gate`

## Requirements
- R1: Function code 0000 gives the bitwise AND of A and B.
- R2: Function code 0001 gives the bitwise OR of A and B.
- R3: Function code 0010 gives A+B modulo 2^16. A carry out of the top bit is dropped.
- R4: Function code 0110 gives A-B modulo 2^16. The adder computes it as A plus the inverted B, with a carry-in of 1.
- R5: Function code 0111 treats A and B as signed two's-complement numbers. It gives 1 in bit 0 when A < B and 0 otherwise. The decision must stay correct when A-B overflows. Bits 15..1 are always 0.
- R6: Function code 1100 gives the bitwise NOR of A and B.
- R7: Function code 1101 gives the bitwise NAND of A and B.
- R8: All other nine function codes give a result of 0.
- R9: The zero flag is 1 exactly when all 16 result bits are 0. This holds for every function code, unused codes included.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand (A) |
| op_b | input | 16 | Second operand (B) |
| alu_ctl | input | 4 | Function code |
| result | output | 16 | Function result |
| zero | output | 1 | High when result is all zeros |

## Verification
The bench checks add with a carry out of the top bit, such as FFFF+1. A design that kept the carry would give a non-zero result and a clear zero flag. It also checks subtract where B is larger than A. A design missing the forced carry-in would be off by one there.

Set-less-than is tested with operand pairs whose difference overflows, such as 8000 against 7FFF. A design that used only the sign of the difference would give the inverted answer.

Every unused function code is applied with non-zero operands. A decoder that let a function leak through would give a non-zero result.

A single set bit is walked across every result position through the adder. A break anywhere in the zero-detect chain would wrongly raise the zero flag for that bit.

// File: rtl/alu16_gate.sv
module alu16_gate #(
  parameter int W = 16
) (
  input  wire [W-1:0] op_a,
  input  wire [W-1:0] op_b,
  input  wire [3:0]   alu_ctl,
  output wire [W-1:0] result,
  output wire         zero
);
  wire nc0, nc1, nc2, nc3;
  wire sel_and, sel_or, sel_add, sel_sub, sel_slt, sel_nor, sel_nand;
  wire inv_b, sel_arith, ovf, less, slt_term;

  not g_nc0 (nc0, alu_ctl[0]);
  not g_nc1 (nc1, alu_ctl[1]);
  not g_nc2 (nc2, alu_ctl[2]);
  not g_nc3 (nc3, alu_ctl[3]);

  and g_dand  (sel_and,  nc3, nc2, nc1, nc0);
  and g_dor   (sel_or,   nc3, nc2, nc1, alu_ctl[0]);
  and g_dadd  (sel_add,  nc3, nc2, alu_ctl[1], nc0);
  and g_dsub  (sel_sub,  nc3, alu_ctl[2], alu_ctl[1], nc0);
  and g_dslt  (sel_slt,  nc3, alu_ctl[2], alu_ctl[1], alu_ctl[0]);
  and g_dnor  (sel_nor,  alu_ctl[3], alu_ctl[2], nc1, nc0);
  and g_dnand (sel_nand, alu_ctl[3], alu_ctl[2], nc1, alu_ctl[0]);

  or g_inv   (inv_b, sel_sub, sel_slt);
  or g_arith (sel_arith, sel_add, sel_sub);

  wire [W:0]   cy;
  wire [W-1:0] bx, sum, orc;

  buf g_cin (cy[0], inv_b);

  for (genvar i = 0; i < W; i++) begin : g_bit
    wire y_and, y_or, y_nor, y_nand, p, g, t;
    wire m_and, m_or, m_nor, m_nand, m_sum;

    xor g_bx  (bx[i], op_b[i], inv_b);
    and g_a   (y_and, op_a[i], op_b[i]);
    or  g_o   (y_or, op_a[i], op_b[i]);
    nor g_no  (y_nor, op_a[i], op_b[i]);
    nand g_na (y_nand, op_a[i], op_b[i]);

    xor g_p  (p, op_a[i], bx[i]);
    xor g_s  (sum[i], p, cy[i]);
    and g_g  (g, op_a[i], bx[i]);
    and g_t  (t, p, cy[i]);
    or  g_c  (cy[i+1], g, t);

    and g_ma  (m_and, sel_and, y_and);
    and g_mo  (m_or, sel_or, y_or);
    and g_mno (m_nor, sel_nor, y_nor);
    and g_mna (m_nand, sel_nand, y_nand);
    and g_ms  (m_sum, sel_arith, sum[i]);

    if (i == 0) begin : g_lsb
      or g_res (result[i], m_and, m_or, m_nor, m_nand, m_sum, slt_term);
      buf g_z0 (orc[i], result[i]);
    end else begin : g_upper
      or g_res (result[i], m_and, m_or, m_nor, m_nand, m_sum);
      or g_zc  (orc[i], orc[i-1], result[i]);
    end
  end

  xor g_ovf  (ovf, cy[W], cy[W-1]);
  xor g_less (less, sum[W-1], ovf);
  and g_slt  (slt_term, sel_slt, less);
  not g_zero (zero, orc[W-1]);
endmodule

// File: rtl/alu16_gate_chk.sv
module alu16_gate_chk #(
  parameter int W = 16
) (
  input wire [W-1:0] op_a,
  input wire [W-1:0] op_b,
  input wire [3:0]   alu_ctl,
  input wire [W-1:0] result,
  input wire         zero
);
  always_comb begin
    p_and_r1: assert (alu_ctl != 4'b0000 || result == (op_a & op_b));
    p_or_r2: assert (alu_ctl != 4'b0001 || result == (op_a | op_b));
    p_add_r3: assert (alu_ctl != 4'b0010 || result == W'(op_a + op_b));
    p_sub_r4: assert (alu_ctl != 4'b0110 || result == W'(op_a - op_b));
    p_slt_r5: assert (alu_ctl != 4'b0111 ||
                      result == {{(W-1){1'b0}}, ($signed(op_a) < $signed(op_b))});
    p_nor_r6: assert (alu_ctl != 4'b1100 || result == ~(op_a | op_b));
    p_nand_r7: assert (alu_ctl != 4'b1101 || result == ~(op_a & op_b));
    p_unused_r8: assert (alu_ctl inside {4'b0000, 4'b0001, 4'b0010, 4'b0110,
                                         4'b0111, 4'b1100, 4'b1101} || result == '0);
    p_zero_r9: assert (zero == (result == '0));
  end
endmodule

bind alu16_gate alu16_gate_chk #(.W(W)) u_chk (.*);

// File: tb/alu16_gate_bench.sv
module alu16_gate_bench;
  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic [W-1:0] op_a = '0, op_b = '0;
  logic [3:0] alu_ctl = 4'b0000;
  wire  [W-1:0] result;
  wire  zero;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu16_gate #(.W(W)) u_alu16_gate (
    .op_a(op_a), .op_b(op_b), .alu_ctl(alu_ctl), .result(result), .zero(zero)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] a, logic [W-1:0] b, logic [3:0] c);
    case (c)
      4'b0000: return a & b;
      4'b0001: return a | b;
      4'b0010: return W'(a + b);
      4'b0110: return W'(a - b);
      4'b0111: return ($signed(a) < $signed(b)) ? W'(1) : '0;
      4'b1100: return ~(a | b);
      4'b1101: return ~(a & b);
      default: return '0;
    endcase
  endfunction

  task automatic run(string tag, logic [W-1:0] a, logic [W-1:0] b, logic [3:0] c);
    logic [W-1:0] er;
    @(posedge clk);
    op_a = a; op_b = b; alu_ctl = c;
    @(negedge clk);
    er = model(a, b, c);
    checks++;
    if (result !== er) begin
      errors++;
      $display("FAIL %s result ctl=%b a=%h b=%h actual=%h expected=%h", tag, c, a, b, result, er);
    end
    checks++;
    if (zero !== (er == '0)) begin
      errors++;
      $display("FAIL R9 zero (%s) ctl=%b actual=%b expected=%b", tag, c, zero, er == '0);
    end
  endtask

  task automatic t_idle();
    @(negedge clk);
    checks++;
    if (result !== '0 || zero !== 1'b1) begin
      errors++;
      $display("FAIL R1 idle actual=%h/%b expected=0000/1", result, zero);
    end
  endtask

  task automatic t_logic();
    run("R1", 16'hF0F0, 16'hFF00, 4'b0000);
    run("R1", 16'h1234, 16'h4321, 4'b0000);
    run("R2", 16'hF0F0, 16'h0F00, 4'b0001);
    run("R2", 16'h0000, 16'h0000, 4'b0001);
    run("R6", 16'hF0F0, 16'h0F00, 4'b1100);
    run("R6", 16'hFFFF, 16'h0000, 4'b1100);
    run("R7", 16'hF0F0, 16'hFF00, 4'b1101);
    run("R7", 16'hFFFF, 16'hFFFF, 4'b1101);
  endtask

  task automatic t_add();
    run("R3", 16'h0001, 16'h0002, 4'b0010);
    run("R3", 16'hFFFF, 16'h0001, 4'b0010);
    run("R3", 16'h7FFF, 16'h0001, 4'b0010);
    run("R3", 16'hABCD, 16'h5433, 4'b0010);
  endtask

  task automatic t_sub();
    run("R4", 16'h0005, 16'h0003, 4'b0110);
    run("R4", 16'h0003, 16'h0005, 4'b0110);
    run("R4", 16'h9A9A, 16'h9A9A, 4'b0110);
    run("R4", 16'h0000, 16'hFFFF, 4'b0110);
  endtask

  task automatic t_slt();
    run("R5", 16'hFFFF, 16'h0001, 4'b0111);
    run("R5", 16'h0001, 16'hFFFF, 4'b0111);
    run("R5", 16'h8000, 16'h7FFF, 4'b0111);
    run("R5", 16'h7FFF, 16'h8000, 4'b0111);
    run("R5", 16'h1234, 16'h1234, 4'b0111);
    run("R5", 16'h0002, 16'h0003, 4'b0111);
  endtask

  task automatic t_unused();
    for (int c = 0; c < 16; c++) begin
      if (!(c inside {0, 1, 2, 6, 7, 12, 13}))
        run("R8", 16'hFFFF, 16'h1234, 4'(c));
    end
  endtask

  task automatic t_walk();
    for (int i = 0; i < W; i++)
      run("R9", W'(1) << i, 16'h0000, 4'b0010);
  endtask

  initial begin
    t_idle();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_unused();
    t_walk();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule